// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the digital output stage of a 16-bit measurement converter. Finished conversion results arrive as a signed raw value with a one-cycle valid strobe. The block forces any result outside the selected input range to the all-ones or all-zeros code, then holds the word. It reports that a word is available by pulling an active-low ready line low. An external host reads the word serially: it lowers an active-low select and toggles a serial clock. The data line is driven as a data bit plus an output enable, and the pad ring combines them into a three-state pin.

The serial clock and the select are asynchronous to the system clock. Each passes through a two-flop synchroniser, and their edges are detected in the system clock domain. Shifting is gated in three ways. A rising serial-clock edge must arm the shifter before any falling edge takes effect. A select release in the middle of a word lets the current bit run to its end before the line floats. A select that falls during the two-cycle window that follows each word update is ignored. A word that arrives during a readout is parked in a pending register and moves into the holding register when the select goes high again.

Top module: `conv_readout_port`

## Requirements
- R1: Unipolar mode (`bipolar`=0) treats `conv_raw` as a signed two's-complement value. A value from 0 to 65535 gives the same 16-bit code. A value above 65535 gives 16'hFFFF, and a negative value gives 16'h0000.
- R2: Bipolar mode (`bipolar`=1) gives offset-binary codes: the output is raw + 32768 for raw from -32768 to 32767. A value above 32767 gives 16'hFFFF, and a value below -32768 gives 16'h0000.
- R3: After reset, and while no word is held, `drdy_n` is 1. Loading a word holds `drdy_n` at 1 for a two-cycle update window, after which it goes to 0.
- R4: Once the select is recognised, `sdo_oe` rises and `sdo` presents bit 15. Each later falling serial-clock edge moves `sdo` to the next lower bit, so the word goes out MSB first. `sdo` changes on no other event.
- R5: After the select is recognised, falling serial-clock edges have no effect until a rising serial-clock edge has been seen.
- R6: The falling serial-clock edge after bit 0 deasserts `sdo_oe` and sets `drdy_n` to 1.
- R7: If `cs_n` rises before the word is complete, `sdo_oe` and `sdo` hold until the next falling serial-clock edge, and then `sdo_oe` drops. The word stays held with `drdy_n`=0, and a later readout starts again at bit 15.
- R8: A falling `cs_n` is not recognised, and `sdo_oe` stays 0, if it occurs while `drdy_n` is 1. This covers both the update window and the case where no word is held.
- R9: A word that arrives during a readout leaves the word being shifted unchanged. It is loaded, with its own update window, after `cs_n` returns high.
- R10: A new word that arrives while the held word is unread replaces it, and `drdy_n` goes to 1 for the update window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_valid | input | 1 | One-cycle strobe: `conv_raw` holds a finished result |
| conv_raw | input | 18 | Signed two's-complement conversion result |
| bipolar | input | 1 | 1 = bipolar offset-binary coding, 0 = unipolar |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| cs_n | input | 1 | Active-low select from the host (asynchronous) |
| drdy_n | output | 1 | Active-low word-available flag |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Output enable for the serial data pad (0 = float) |

## Verification
The hardest states to reach from the ports are those in which two asynchronous events collide: a select edge that lands inside the two-cycle update window, and a new result that arrives halfway through a shift. The bench lowers `cs_n` on the same cycle as the `conv_valid` strobe, so the synchronised edge reaches the block while the window is still open. It then confirms that the line stays floating until the select is cycled. To build the other collision, it pulses `conv_valid` between serial-clock edges of a readout that is already under way. It then checks both the word already in flight and the parked word, which becomes visible only after the select is released.

// File: rtl/conv_rd_pkg.sv
package conv_rd_pkg;
    localparam int DEF_WORD_W = 16;
    localparam int DEF_RAW_W  = 18;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_ARM,
        ENG_SHIFT,
        ENG_TAIL,
        ENG_DONE
    } eng_state_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic prev_o
);
    // chain_q[STAGES-1] is the synchronised level; chain_q[STAGES] is its history.
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {(STAGES + 1){RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
    assign prev_o  = chain_q[STAGES];
endmodule

// File: rtl/range_clamp.sv
module range_clamp #(
    parameter int WORD_W = conv_rd_pkg::DEF_WORD_W,
    parameter int RAW_W  = conv_rd_pkg::DEF_RAW_W
) (
    input  logic [RAW_W-1:0]  raw_i,
    input  logic              bipolar_i,
    output logic [WORD_W-1:0] word_o
);
    localparam logic signed [RAW_W-1:0] UMAX = RAW_W'((1 << WORD_W) - 1);
    localparam logic signed [RAW_W-1:0] BMAX = RAW_W'((1 << (WORD_W - 1)) - 1);
    localparam logic signed [RAW_W-1:0] BMIN = -BMAX - RAW_W'(1);

    logic signed [RAW_W-1:0] sraw;
    logic signed [RAW_W-1:0] biased;

    always_comb begin
        sraw   = $signed(raw_i);
        biased = sraw - BMIN;
        if (!bipolar_i) begin
            if (sraw > UMAX)                   word_o = '1;
            else if (sraw < $signed(RAW_W'(0))) word_o = '0;
            else                               word_o = sraw[WORD_W-1:0];
        end else begin
            if (sraw > BMAX)      word_o = '1;
            else if (sraw < BMIN) word_o = '0;
            else                  word_o = biased[WORD_W-1:0];
        end
    end
endmodule

// File: rtl/shift_engine.sv
module shift_engine #(
    parameter int WORD_W = conv_rd_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low_i,
    input  logic              cs_fall_i,
    input  logic              sclk_rise_i,
    input  logic              sclk_fall_i,
    input  logic              word_ready_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sdo_o,
    output logic              oe_o,
    output logic              busy_o,
    output logic              done_o
);
    import conv_rd_pkg::*;

    localparam int CNT_W = $clog2(WORD_W);

    typedef struct packed {
        eng_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             sdo;
        logic             oe;
    } eng_t;

    eng_t eng_d, eng_q;
    logic done_d;
    logic [CNT_W-1:0] nidx;

    always_comb begin
        eng_d  = eng_q;
        done_d = 1'b0;
        nidx   = eng_q.cnt - CNT_W'(1);
        unique case (eng_q.st)
            ENG_IDLE: begin
                if (cs_fall_i && word_ready_i) begin
                    eng_d.st  = ENG_ARM;
                    eng_d.cnt = CNT_W'(WORD_W - 1);
                    eng_d.sdo = word_i[WORD_W-1];
                    eng_d.oe  = 1'b1;
                end
            end
            ENG_ARM: begin
                if (!cs_low_i) begin
                    eng_d.st = ENG_IDLE;
                    eng_d.oe = 1'b0;
                end else if (sclk_rise_i) begin
                    eng_d.st = ENG_SHIFT;
                end
            end
            ENG_SHIFT: begin
                if (sclk_fall_i && eng_q.cnt == '0) begin
                    done_d   = 1'b1;
                    eng_d.oe = 1'b0;
                    eng_d.st = cs_low_i ? ENG_DONE : ENG_IDLE;
                end else if (sclk_fall_i && !cs_low_i) begin
                    eng_d.st = ENG_IDLE;
                    eng_d.oe = 1'b0;
                end else if (sclk_fall_i) begin
                    eng_d.cnt = nidx;
                    eng_d.sdo = word_i[nidx];
                end else if (!cs_low_i) begin
                    eng_d.st = ENG_TAIL;
                end
            end
            ENG_TAIL: begin
                if (sclk_fall_i) begin
                    eng_d.st = ENG_IDLE;
                    eng_d.oe = 1'b0;
                end
            end
            ENG_DONE: begin
                if (!cs_low_i) eng_d.st = ENG_IDLE;
            end
            default: eng_d = '{st: ENG_IDLE, cnt: '0, sdo: 1'b0, oe: 1'b0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{st: ENG_IDLE, cnt: '0, sdo: 1'b0, oe: 1'b0};
        else        eng_q <= eng_d;
    end

    assign sdo_o  = eng_q.sdo;
    assign oe_o   = eng_q.oe;
    assign busy_o = (eng_q.st != ENG_IDLE);
    assign done_o = done_d;

    // R4: while driving, the bit only moves on a falling serial-clock edge
    assert_hold_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.oe && !sclk_fall_i) |=> $stable(eng_q.sdo));

    // R5: arming state keeps the first bit index until a rising edge arms
    assert_arm_keeps_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ENG_ARM) |=> (eng_q.cnt == CNT_W'(WORD_W - 1)));

    // R6: the edge after the last bit floats the line
    assert_float_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ENG_SHIFT && sclk_fall_i && eng_q.cnt == '0) |=> !eng_q.oe);

    // R7: a released select keeps driving until the bit period ends
    assert_tail_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ENG_TAIL && !sclk_fall_i) |=> eng_q.oe);
endmodule

// File: rtl/conv_readout_port.sv
module conv_readout_port #(
    parameter int WORD_W   = conv_rd_pkg::DEF_WORD_W,
    parameter int RAW_W    = conv_rd_pkg::DEF_RAW_W,
    parameter int SYNC_STG = 2,
    parameter int WIN_CYC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_valid,
    input  logic [RAW_W-1:0] conv_raw,
    input  logic             bipolar,
    input  logic             sclk,
    input  logic             cs_n,
    output logic             drdy_n,
    output logic             sdo,
    output logic             sdo_oe
);
    localparam int WIN_W = $clog2(WIN_CYC + 1);

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic              hold_full;
        logic [WIN_W-1:0]  win;
        logic [WORD_W-1:0] pend;
        logic              pend_full;
    } port_t;

    port_t p_d, p_q;

    logic [WORD_W-1:0] clamped;
    logic sclk_lvl, sclk_prev, cs_lvl, cs_prev;
    logic sclk_rise, sclk_fall, cs_fall, cs_low;
    logic word_ready, busy, done;

    range_clamp #(.WORD_W(WORD_W), .RAW_W(RAW_W)) u_clamp (
        .raw_i(conv_raw), .bipolar_i(bipolar), .word_o(clamped)
    );

    edge_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .async_i(sclk),
        .level_o(sclk_lvl), .prev_o(sclk_prev)
    );

    edge_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .async_i(cs_n),
        .level_o(cs_lvl), .prev_o(cs_prev)
    );

    assign sclk_rise = sclk_lvl & ~sclk_prev;
    assign sclk_fall = ~sclk_lvl & sclk_prev;
    assign cs_fall   = ~cs_lvl & cs_prev;
    assign cs_low    = ~cs_lvl;

    // A start is refused while the held word may change in the same cycle.
    assign word_ready = p_q.hold_full && (p_q.win == '0) && !conv_valid && !p_q.pend_full;

    shift_engine #(.WORD_W(WORD_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .cs_low_i(cs_low), .cs_fall_i(cs_fall),
        .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
        .word_ready_i(word_ready), .word_i(p_q.hold),
        .sdo_o(sdo), .oe_o(sdo_oe), .busy_o(busy), .done_o(done)
    );

    always_comb begin
        p_d = p_q;
        if (p_q.win != '0) p_d.win = p_q.win - WIN_W'(1);
        if (done) p_d.hold_full = 1'b0;
        if (conv_valid && !busy) begin
            p_d.hold      = clamped;
            p_d.hold_full = 1'b1;
            p_d.win       = WIN_W'(WIN_CYC);
            p_d.pend_full = 1'b0;
        end else if (conv_valid) begin
            p_d.pend      = clamped;
            p_d.pend_full = 1'b1;
        end else if (!busy && p_q.pend_full) begin
            p_d.hold      = p_q.pend;
            p_d.hold_full = 1'b1;
            p_d.win       = WIN_W'(WIN_CYC);
            p_d.pend_full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign drdy_n = !(p_q.hold_full && p_q.win == '0);

    // R3: a load opens the update window on the next cycle
    assert_window_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && !busy) |=> drdy_n);

    // R8: the line is only driven while a word is held
    assert_oe_needs_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> p_q.hold_full);

    // R9: a word arriving mid-readout leaves the shifted word alone
    assert_pending_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_valid) |=> $stable(p_q.hold));
endmodule

// File: tb/conv_readout_port_test.sv
module conv_readout_port_test;
    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [17:0] conv_raw = '0;
    logic        bipolar = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        drdy_n, sdo, sdo_oe;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [15:0] got;

    always #2 clk = ~clk;

    conv_readout_port uut (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_raw(conv_raw),
        .bipolar(bipolar), .sclk(sclk), .cs_n(cs_n),
        .drdy_n(drdy_n), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    // {raw, bipolar, expected code}
    localparam logic [34:0] VEC [11] = '{
        {18'h01234, 1'b0, 16'h1234},   // R1 in range
        {18'h0FFFF, 1'b0, 16'hFFFF},   // R1 at full scale
        {18'h10000, 1'b0, 16'hFFFF},   // R1 above
        {18'h3FFFF, 1'b0, 16'h0000},   // R1 below zero
        {18'h00000, 1'b1, 16'h8000},   // R2 zero
        {18'h07FFF, 1'b1, 16'hFFFF},   // R2 +FS
        {18'h08000, 1'b1, 16'hFFFF},   // R2 above
        {18'h38000, 1'b1, 16'h0000},   // R2 -FS
        {18'h37FFF, 1'b1, 16'h0000},   // R2 below
        {18'h3FFFF, 1'b1, 16'h7FFF},   // R2 -1
        {18'h0A5C3, 1'b0, 16'hA5C3}    // R1 pattern
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [17:0] raw, input logic bip);
        @(negedge clk);
        conv_raw = raw; bipolar = bip; conv_valid = 1'b1;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    task automatic begin_read();
        cs_n = 1'b0; waitc(HP);
        got = {15'b0, sdo};
        chk("R4", "oe at select", 32'(sdo_oe), 32'd1);
        sclk = 1'b1; waitc(HP);
    endtask

    task automatic step_bits(input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0; waitc(HP);
            got = {got[14:0], sdo};
            sclk = 1'b1; waitc(HP);
        end
    endtask

    task automatic full_read(input string req, input logic [15:0] exp);
        begin_read();
        step_bits(15);
        sclk = 1'b0; waitc(HP);
        chk(req, "word", 32'(got), 32'(exp));
        chk("R6", "oe after last", 32'(sdo_oe), 32'd0);
        chk("R6", "drdy after last", 32'(drdy_n), 32'd1);
        cs_n = 1'b1; waitc(HP);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(3);
        chk("R3", "drdy at reset", 32'(drdy_n), 32'd1);
        chk("R8", "oe at reset", 32'(sdo_oe), 32'd0);

        // R8: select with no word held
        cs_n = 1'b0; waitc(HP);
        chk("R8", "oe with no word", 32'(sdo_oe), 32'd0);
        cs_n = 1'b1; waitc(HP);

        // Table walk: R1, R2, R4, R6
        for (int v = 0; v < 11; v++) begin
            load(VEC[v][34:17], VEC[v][16]);
            waitc(4);
            chk("R3", "drdy after window", 32'(drdy_n), 32'd0);
            full_read(VEC[v][16] ? "R2" : "R1", VEC[v][15:0]);
        end

        // R10: replacement of an unread word
        load(18'h00111, 1'b0);
        waitc(6);
        load(18'h00222, 1'b0);
        chk("R10", "drdy in window", 32'(drdy_n), 32'd1);
        waitc(4);
        full_read("R10", 16'h0222);

        // R8: select falls inside the update window
        @(negedge clk);
        conv_raw = 18'h04C4C; bipolar = 1'b0; conv_valid = 1'b1; cs_n = 1'b0;
        @(negedge clk);
        conv_valid = 1'b0;
        waitc(20);
        chk("R8", "oe after window select", 32'(sdo_oe), 32'd0);
        chk("R3", "drdy word held", 32'(drdy_n), 32'd0);
        cs_n = 1'b1; waitc(HP);
        full_read("R8", 16'h4C4C);

        // R5: falling edge before arming does nothing
        load(18'h08001, 1'b0);
        waitc(4);
        sclk = 1'b1; waitc(HP);
        cs_n = 1'b0; waitc(HP);
        chk("R5", "msb presented", 32'(sdo), 32'd1);
        sclk = 1'b0; waitc(HP);
        chk("R5", "unarmed fall", 32'(sdo), 32'd1);
        chk("R5", "oe unarmed", 32'(sdo_oe), 32'd1);
        sclk = 1'b1; waitc(HP);
        sclk = 1'b0; waitc(HP);
        chk("R4", "second bit", 32'(sdo), 32'd0);
        // R7: release while bit 14 is in progress
        cs_n = 1'b1; waitc(HP);
        chk("R7", "oe held after release", 32'(sdo_oe), 32'd1);
        chk("R7", "bit held after release", 32'(sdo), 32'd0);
        sclk = 1'b1; waitc(HP);
        chk("R7", "oe held over rise", 32'(sdo_oe), 32'd1);
        sclk = 1'b0; waitc(HP);
        chk("R7", "oe after bit end", 32'(sdo_oe), 32'd0);
        chk("R7", "word still held", 32'(drdy_n), 32'd0);
        full_read("R7", 16'h8001);

        // R7: release with the clock high during bit 13
        load(18'h0A5C3, 1'b0);
        waitc(4);
        begin_read();
        step_bits(2);
        cs_n = 1'b1; waitc(HP);
        chk("R7", "bit13 held", 32'(sdo), 32'd1);
        chk("R7", "oe bit13", 32'(sdo_oe), 32'd1);
        sclk = 1'b0; waitc(HP);
        chk("R7", "float after bit13", 32'(sdo_oe), 32'd0);
        full_read("R7", 16'hA5C3);

        // R9: word arrives in the middle of a readout
        load(18'h01357, 1'b0);
        waitc(4);
        begin_read();
        step_bits(5);
        load(18'h02468, 1'b0);
        step_bits(10);
        sclk = 1'b0; waitc(HP);
        chk("R9", "word in flight", 32'(got), 32'h1357);
        chk("R9", "pending hidden", 32'(drdy_n), 32'd1);
        cs_n = 1'b1; waitc(HP);
        chk("R9", "pending ready", 32'(drdy_n), 32'd0);
        full_read("R9", 16'h2468);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule